// File: doc/BRIEF.md
# Dual-Mode I2C Serial Clock Generator

This block produces the serial clock for an I2C controller from the system clock. It has two timing schemes. In the standard/fast scheme, a small prescaler slows the system clock into an internal tick, and one coarse divider value sets the length of both clock phases. In the fast-mode-plus scheme, the prescaler is skipped. The LOW and HIGH phases are then built from separately programmed counts plus a shared mask count, all in system-clock cycles.

The line is open-drain, so the block only ever pulls SCL low. It reads the line back and starts counting the HIGH phase only once the line is really high. This absorbs the rise time and any clock stretching by a target. When the block is enabled, it first holds the line released for a fixed setup window so that SDA can settle. After that it starts the first LOW phase.

The block gives the bit engine three outputs:
- a one-cycle strobe at the start of every phase;
- a strobe marking the first LOW phase after the setup window;
- in fast-mode-plus, a window at the start of each LOW phase during which SDA must not change.

Top module: `scl_dual_gen`

## Requirements
- R1: While `rst_n` is low, or from the cycle after `en` is sampled low, `scl_pull`, `phase_stb`, `first_stb` and `sda_hold` are all 0.
- R2: After `en` is sampled high from the idle state, the line stays released for exactly 17 cycles. In the next cycle, `scl_pull` rises and `first_stb` is 1 for that single cycle only.
- R3: With `mode_cfg[7]`=0, `div_cfg` holds the coarse divider G in its upper 6 bits and the prescale value P in its lower 3 bits. Each LOW phase lasts (10+4·G)·(1+P) cycles. Each HIGH phase lasts (10+4·G)·(1+P) cycles in which `scl_in` is high.
- R4: With `mode_cfg[7]`=1 and `mode_cfg[1]`=1, the LOW phase lasts `low_cnt`+`mask_cnt`+4 cycles and the HIGH phase lasts `high_cnt`+`mask_cnt`+4 cycles, with the prescale value ignored.
- R5: With `mode_cfg[7]`=1 and `mode_cfg[1]`=0, the HIGH phase uses `low_cnt` in place of `high_cnt`.
- R6: With `mode_cfg[7]`=1 and `mode_cfg[0]`=1, `sda_hold` is 1 during the first `mask_cnt` cycles of each LOW phase. It is 0 at all other times, and it is always 0 when `mode_cfg[0]`=0 or `mode_cfg[7]`=0.
- R7: `mode_cfg` bits 2, 1 and 0 have no effect when `mode_cfg[7]`=0. Bit 2 has no effect in either scheme.
- R8: The HIGH phase counter advances only in cycles where `scl_in` is high. A target holding the line low lengthens the HIGH phase by exactly those cycles.
- R9: The timing inputs are sampled only at the edge that starts a LOW phase. A change during a period takes effect from the next period on.
- R10: `phase_stb` is 1 exactly in the first cycle of every LOW phase and of every HIGH phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low releases the line and clears all counters |
| div_cfg | input | 9 | Coarse divider (upper 6 bits) above prescale value (lower 3 bits) |
| mode_cfg | input | 8 | Bit 7 fast-mode-plus, bit 2 prescaler off (no effect), bit 1 separate HIGH count, bit 0 SDA mask enable |
| low_cnt | input | 8 | Fast-mode-plus LOW count |
| high_cnt | input | 8 | Fast-mode-plus HIGH count |
| mask_cnt | input | 8 | Fast-mode-plus mask count |
| scl_in | input | 1 | Sampled SCL line level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| phase_stb | output | 1 | First cycle of each LOW or HIGH phase |
| first_stb | output | 1 | First LOW cycle after the setup window |
| sda_hold | output | 1 | SDA change blocked (fast-mode-plus mask window) |

## Verification
A behavioural model of phase lengths is compared against the outputs every cycle, across a range of configurations:
- Standard-scheme settings: zero divider, a mid setting, and the largest divider with the largest prescale. These tell apart the per-tick and per-cycle counting and the packing of the two fields.
- Fast-mode-plus: with and without separate HIGH control, and with and without the mask. These distinguish which count feeds the HIGH phase and where the hold window lies.
- Standard scheme with stray mode bits set, to show they are ignored.
- A change to the timing inputs in mid-period, to show it is deferred.
- Stretch pulses during HIGH phases, to show the counter pauses.
- Disable and re-enable in mid-run, to show the release and the 17-cycle setup.

// File: rtl/scl_gen_pkg.sv
// Shared types and mode-bit positions for the dual-mode SCL generator.
// Assumes: the mode register bit positions below are fixed by software.
package scl_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } scl_state_e;

    localparam int MODE_FMP_BIT  = 7;  // fast-mode-plus select
    localparam int MODE_NOPS_BIT = 2;  // prescaler off (always implied by FMP)
    localparam int MODE_SEP_BIT  = 1;  // separate HIGH count
    localparam int MODE_MASK_BIT = 0;  // SDA mask window enable
endpackage

// File: rtl/scl_prescaler.sv
// Divides the advance condition by (div+1) into a tick.
// Assumes: div is stable between clears; clr restarts the count.
module scl_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt;

    assign tick = adv && (pcnt == div);

    // Count advance cycles, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pcnt <= '0;
        else if (adv)      pcnt <= tick ? '0 : pcnt + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && div != '0) |=> !tick); // R3
endmodule

// File: rtl/scl_phase_timer.sv
// Counts ticks within one SCL phase and flags the final tick.
// Assumes: len >= 1 and only changes together with clr.
module scl_phase_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    output logic             done,
    output logic [CNT_W-1:0] elapsed
);
    assign done = tick && (elapsed == len - CNT_W'(1));

    // Tick counter, restarted at every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) elapsed <= '0;
        else if (tick)     elapsed <= elapsed + 1'b1;
    end

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed < len); // R4
endmodule

// File: rtl/scl_setup_timer.sv
// Times the first-bit setup window while run is held.
// Assumes: run drops for at least one cycle between windows.
module scl_setup_timer #(
    parameter int SETUP_CYC = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int SW = $clog2(SETUP_CYC + 1);
    logic [SW-1:0] scnt;

    assign done = run && (scnt == SW'(SETUP_CYC - 1));

    // Count cycles spent in the setup window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) scnt <= '0;
        else                scnt <= scnt + 1'b1;
    end
endmodule

// File: rtl/scl_dual_gen.sv
// Dual-mode SCL generator: setup window, then alternating LOW/HIGH phases.
// Standard scheme uses a prescaled 20+8G period; fast-mode-plus uses
// per-phase counts. Timing inputs are latched at each LOW-phase start.
// Assumes: scl_in is already synchronised to clk.
module scl_dual_gen
    import scl_gen_pkg::*;
#(
    parameter int CDF_W     = 3,
    parameter int SCGD_W    = 6,
    parameter int TIME_W    = 8,
    parameter int SETUP_CYC = 17
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic [SCGD_W+CDF_W-1:0]   div_cfg,
    input  logic [7:0]                mode_cfg,
    input  logic [TIME_W-1:0]         low_cnt,
    input  logic [TIME_W-1:0]         high_cnt,
    input  logic [TIME_W-1:0]         mask_cnt,
    input  logic                      scl_in,
    output logic                      scl_pull,
    output logic                      phase_stb,
    output logic                      first_stb,
    output logic                      sda_hold
);
    localparam int NRM_W = SCGD_W + 3;
    localparam int FMP_W = TIME_W + 2;
    localparam int CNT_W = (NRM_W > FMP_W) ? NRM_W : FMP_W;

    scl_state_e state, nxt;
    logic fresh, from_setup;
    logic sh_fmp, sh_sep, sh_mask;
    logic [CDF_W-1:0]  sh_cdf;
    logic [SCGD_W-1:0] sh_scgd;
    logic [TIME_W-1:0] sh_scld, sh_schd, sh_smd;

    logic clr, adv, tick, ph_done, setup_done;
    logic [CDF_W-1:0] div_eff;
    logic [CNT_W-1:0] low_len, high_len, cur_len, elapsed;

    // Phase lengths derived from the latched configuration.
    always_comb begin
        if (sh_fmp) begin
            low_len  = CNT_W'(sh_scld) + CNT_W'(sh_smd) + CNT_W'(4);
            high_len = CNT_W'(sh_sep ? sh_schd : sh_scld) + CNT_W'(sh_smd) + CNT_W'(4);
            div_eff  = '0;
        end else begin
            low_len  = CNT_W'(10) + (CNT_W'(sh_scgd) << 2);
            high_len = low_len;
            div_eff  = sh_cdf;
        end
        cur_len = (state == ST_HIGH) ? high_len : low_len;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        if (!en) nxt = ST_IDLE;
        else begin
            case (state)
                ST_IDLE:  nxt = ST_SETUP;
                ST_SETUP: if (setup_done) nxt = ST_LOW;
                ST_LOW:   if (ph_done)    nxt = ST_HIGH;
                ST_HIGH:  if (ph_done)    nxt = ST_LOW;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    assign clr = (nxt != state);
    assign adv = (state == ST_LOW) || ((state == ST_HIGH) && scl_in);

    // State, strobe flags and configuration shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            fresh      <= 1'b0;
            from_setup <= 1'b0;
            sh_fmp     <= 1'b0;
            sh_sep     <= 1'b0;
            sh_mask    <= 1'b0;
            sh_cdf     <= '0;
            sh_scgd    <= '0;
            sh_scld    <= '0;
            sh_schd    <= '0;
            sh_smd     <= '0;
        end else begin
            state      <= nxt;
            fresh      <= clr && (nxt == ST_LOW || nxt == ST_HIGH);
            from_setup <= (state == ST_SETUP) && (nxt == ST_LOW);
            if (nxt == ST_LOW && state != ST_LOW) begin
                sh_fmp  <= mode_cfg[MODE_FMP_BIT];
                sh_sep  <= mode_cfg[MODE_SEP_BIT];
                sh_mask <= mode_cfg[MODE_MASK_BIT];
                sh_cdf  <= div_cfg[CDF_W-1:0];
                sh_scgd <= div_cfg[SCGD_W+CDF_W-1:CDF_W];
                sh_scld <= low_cnt;
                sh_schd <= high_cnt;
                sh_smd  <= mask_cnt;
            end
        end
    end

    scl_prescaler #(.DIV_W(CDF_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .div(div_eff), .tick(tick)
    );

    scl_phase_timer #(.CNT_W(CNT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .len(cur_len),
        .done(ph_done), .elapsed(elapsed)
    );

    scl_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_setup (
        .clk(clk), .rst_n(rst_n), .run(state == ST_SETUP), .done(setup_done)
    );

    assign scl_pull  = (state == ST_LOW);
    assign phase_stb = fresh;
    assign first_stb = from_setup;
    assign sda_hold  = (state == ST_LOW) && sh_fmp && sh_mask && (elapsed < CNT_W'(sh_smd));

    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull && !phase_stb && !first_stb && !sda_hold)); // R1
    AST_FIRST_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        first_stb |-> (scl_pull && phase_stb)); // R2
    AST_HOLD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sda_hold |-> scl_pull); // R6
    AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH && !scl_in && en) |=> (state == ST_HIGH)); // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH || (state == ST_LOW && !phase_stb)) |->
        ($stable(sh_fmp) && $stable(sh_scgd) && $stable(sh_cdf) && $stable(sh_scld)
         && $stable(sh_schd) && $stable(sh_smd))); // R9
endmodule

// File: tb/tb_scl_dual_gen.sv
module tb_scl_dual_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [8:0] div_cfg = '0;
    logic [7:0] mode_cfg = '0;
    logic [7:0] low_cnt = '0, high_cnt = '0, mask_cnt = '0;
    logic stretch = 1'b0;
    logic scl_in;
    logic scl_pull, phase_stb, first_stb, sda_hold;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit cmp_on = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign scl_in = !scl_pull && !stretch;

    scl_dual_gen dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_cfg(div_cfg), .mode_cfg(mode_cfg),
        .low_cnt(low_cnt), .high_cnt(high_cnt), .mask_cnt(mask_cnt), .scl_in(scl_in),
        .scl_pull(scl_pull), .phase_stb(phase_stb), .first_stb(first_stb), .sda_hold(sda_hold)
    );

    // Reference model: 0 idle, 1 setup, 2 low, 3 high.
    int m_st = 0, m_k = 0;
    bit m_first = 0, m_fromsetup = 0;
    int m_fmp = 0, m_sep = 0, m_mask = 0, m_cdf = 0, m_scgd = 0, m_scld = 0, m_schd = 0, m_smd = 0;

    function automatic int low_total();
        if (m_fmp != 0) return m_scld + m_smd + 4;
        return (10 + 4 * m_scgd) * (m_cdf + 1);
    endfunction

    function automatic int high_total();
        if (m_fmp != 0) return ((m_sep != 0) ? m_schd : m_scld) + m_smd + 4;
        return (10 + 4 * m_scgd) * (m_cdf + 1);
    endfunction

    task automatic enter_low();
        m_fmp  = mode_cfg[7];
        m_sep  = mode_cfg[1];
        m_mask = mode_cfg[0];
        m_cdf  = div_cfg[2:0];
        m_scgd = div_cfg[8:3];
        m_scld = low_cnt;
        m_schd = high_cnt;
        m_smd  = mask_cnt;
        m_st = 2; m_k = 0; m_first = 1;
    endtask

    always @(posedge clk) begin
        bit hi;
        hi = (m_st != 2) && !stretch;
        m_first = 0; m_fromsetup = 0;
        if (!rst_n || !en) begin
            m_st = 0; m_k = 0;
        end else begin
            case (m_st)
                0: begin m_st = 1; m_k = 0; end
                1: begin m_k++; if (m_k == 17) begin enter_low(); m_fromsetup = 1; end end
                2: begin m_k++; if (m_k == low_total()) begin m_st = 3; m_k = 0; m_first = 1; end end
                default: begin if (hi) m_k++; if (m_k == high_total()) enter_low(); end
            endcase
        end
        cmp_on = 1'b1;
    end

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("scl_pull (R3 R4 R5 R8 R9)", scl_pull, m_st == 2);
            chk("phase_stb (R10)", phase_stb, m_first);
            chk("first_stb (R2)", first_stb, m_fromsetup);
            chk("sda_hold (R6)", sda_hold, (m_st == 2) && m_fmp != 0 && m_mask != 0 && m_k < m_smd);
        end
    end

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_up();
    end

    initial begin
        cur_req = "R1 reset";
        run(5);
        rst_n = 1'b1;
        run(3);

        cur_req = "R2 R3 zero divider";
        en = 1'b1;
        run(100);

        cur_req = "R3 R9 divider change mid-period";
        run(7);
        div_cfg = {6'd2, 3'd1};
        run(250);

        cur_req = "R7 stray mode bits";
        mode_cfg = 8'h07;
        run(200);

        cur_req = "R4 R10 fast-mode-plus separate";
        mode_cfg = 8'h83; low_cnt = 8'd20; high_cnt = 8'd10; mask_cnt = 8'd3;
        run(200);

        cur_req = "R5 shared HIGH count";
        mode_cfg = 8'h81; mask_cnt = 8'd5;
        run(200);

        cur_req = "R6 mask disabled";
        mode_cfg = 8'h86;
        run(150);
        mode_cfg = 8'h87;
        run(150);

        cur_req = "R8 stretch";
        for (int i = 0; i < 3; i++) begin
            while (scl_pull) run(1);
            run(2);
            stretch = 1'b1;
            run(25 + i * 7);
            stretch = 1'b0;
            run(60);
        end

        cur_req = "R1 R2 disable and re-enable";
        run(11);
        en = 1'b0;
        run(30);
        en = 1'b1;
        run(150);

        cur_req = "R3 largest divider";
        mode_cfg = 8'h00; div_cfg = {6'd63, 3'd7};
        run(8800);

        cur_req = "R3 prescale only";
        div_cfg = {6'd0, 3'd7};
        run(4500);
        run(400);

        cur_req = "R1 final disable";
        en = 1'b0;
        run(20);

        finish_up();
    end
endmodule